// File: doc/BRIEF.md
# Cascaded Free-Running Cycle Counter

This block keeps a wide free-running count of system clock activity by joining two narrow up-counters. A prescaler divides the system clock by eight and advances the lower stage. The lower stage makes a square carry waveform from two compare points on its own value. Each rising edge of that waveform, detected in the system clock domain, advances the upper stage. Together the two stages form one count that wraps at its full width.

The combined value cannot be read in one step without risk. A read may see the lower half just after it wraps and the upper half just before it steps. A small sequencer avoids this. It takes a request, samples the upper half, then the lower half, then the upper half again. If the two upper samples agree, it returns the concatenation with a one-cycle valid pulse. If they differ, it starts the sampling again. A synchronous restart input clears the prescaler and both stages in the same cycle, so the halves always start aligned.

Top module: `chain_ctr32`

## Requirements
- R1: While rst_ni is low, the prescaler and both stages are held at zero and the sequencer is idle. rd_valid_o is 0 and rd_data_o is all zeros.
- R2: The lower stage advances by exactly one every PRESCALE (default 8) clock cycles. It never steps by any other amount and wraps from all ones to zero. After n clock edges since reset release or restart, the lower half is floor(n/8) mod 2^LO_W.
- R3: The carry waveform is set while the lower value is zero and cleared when the lower value reaches half its range (the MSB alone set). The upper stage steps by one, one clock cycle after the lower stage wraps to zero, and at no other time.
- R4: A returned value carries the upper stage in bits [LO_W+HI_W-1:LO_W] and the lower stage in bits [LO_W-1:0]. It equals floor(n/8) mod 2^(LO_W+HI_W), where n is the edge count at the moment the lower half was sampled.
- R5: A request seen at an idle edge A takes the first upper sample at A, the lower sample at A+1 and the second upper sample at A+2. If the two upper samples match, rd_valid_o is high during the cycle after edge A+2.
- R6: If the two upper samples differ, no result is given. The second upper sample becomes the first of a new attempt, and the lower half is sampled again on the next edge. A mixed value is never returned.
- R7: rd_valid_o is high for exactly one cycle per completed read. rd_req_i is ignored while a read is in progress, including at the edge where the result is produced.
- R8: restart_i high at an edge clears the prescaler and both stages, so the next count starts at zero. It also abandons any read in progress without a valid pulse, and a request at that same edge is ignored.
- R9: The combined count wraps from all ones to zero at 2^(LO_W+HI_W) prescaled ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| restart_i | input | 1 | Synchronous clear of prescaler, both stages and sequencer |
| rd_req_i | input | 1 | Read request, sampled only while idle |
| rd_valid_o | output | 1 | One-cycle pulse marking a coherent result |
| rd_data_o | output | LO_W+HI_W | Last coherent count: upper stage on top, lower stage below |

## Verification
The hardest case to reach from the ports is a read whose lower sample lands in the one cycle where the lower half has already wrapped to zero but the upper half has not yet stepped. Only that case forces a retry. The bench builds the counter with a narrow lower stage so that wraps come quickly. It aligns the count with restart_i and then sweeps the request edge one cycle at a time across the first wrap, so every phase of the read window meets the wrap once. The bench confirms that at least one retry happened, and it also drives reads continuously through a wrap of the full combined width.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_LO   = 2'd1,
    SEQ_HI2  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/ctr_prescale.sv
module ctr_prescale #(
  parameter int DIV = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  output logic tick_o
);
  localparam int PW = (DIV < 2) ? 1 : $clog2(DIV);
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (restart_i)    cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);

  // R2
  tick_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/ctr_low_stage.sv
module ctr_low_stage #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         restart_i,
  input  logic         tick_i,
  output logic [W-1:0] cnt_o,
  output logic         carry_rise_o
);
  localparam logic [W-1:0] HALF = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] lo_q;
  logic         wave_q, wave_d;

  always_comb begin
    wave_d = wave_q;
    if (lo_q == '0)        wave_d = 1'b1;
    else if (lo_q == HALF) wave_d = 1'b0;
  end

  // wave resets high so a fresh zero is not taken as a carry
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q   <= '0;
      wave_q <= 1'b1;
    end else if (restart_i) begin
      lo_q   <= '0;
      wave_q <= 1'b1;
    end else begin
      if (tick_i) lo_q <= lo_q + 1'b1;
      wave_q <= wave_d;
    end
  end

  assign cnt_o        = lo_q;
  assign carry_rise_o = wave_d & ~wave_q;

  // R2
  lo_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(lo_q) && !$past(restart_i)) |-> (lo_q == $past(lo_q) + 1'b1));

  // R3
  wave_low_half_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wave_q && !$past(restart_i)) |-> (lo_q >= HALF || lo_q == '0));
endmodule

// File: rtl/ctr_high_stage.sv
module ctr_high_stage #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         restart_i,
  input  logic         step_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        hi_q <= '0;
    else if (restart_i) hi_q <= '0;
    else if (step_i)    hi_q <= hi_q + 1'b1;
  end

  assign cnt_o = hi_q;
endmodule

// File: rtl/ctr_read_seq.sv
module ctr_read_seq
  import cnt_pkg::*;
#(
  parameter int LO_W = 16,
  parameter int HI_W = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 restart_i,
  input  logic                 req_i,
  input  logic [LO_W-1:0]      lo_i,
  input  logic [HI_W-1:0]      hi_i,
  output logic                 valid_o,
  output logic [LO_W+HI_W-1:0] data_o
);
  localparam int W = LO_W + HI_W;

  seq_state_e     state_q;
  logic [HI_W-1:0] h1_q;
  logic [LO_W-1:0] l_q;
  logic            valid_q;
  logic [W-1:0]    data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      h1_q    <= '0;
      l_q     <= '0;
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= 1'b0;
      if (restart_i) begin
        state_q <= SEQ_IDLE;
      end else begin
        unique case (state_q)
          SEQ_IDLE: if (req_i) begin
            h1_q    <= hi_i;
            state_q <= SEQ_LO;
          end
          SEQ_LO: begin
            l_q     <= lo_i;
            state_q <= SEQ_HI2;
          end
          SEQ_HI2: begin
            if (hi_i == h1_q) begin
              data_q  <= {h1_q, l_q};
              valid_q <= 1'b1;
              state_q <= SEQ_IDLE;
            end else begin
              // second sample opens the next attempt
              h1_q    <= hi_i;
              state_q <= SEQ_LO;
            end
          end
          default: state_q <= SEQ_IDLE;
        endcase
      end
    end
  end

  assign valid_o = valid_q;
  assign data_o  = data_q;

  // R7
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> !valid_q);

  // R6
  coherent_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |-> (data_q[W-1:LO_W] == $past(hi_i)));

  // R8
  restart_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(restart_i) |-> !valid_q);
endmodule

// File: rtl/chain_ctr32.sv
module chain_ctr32 #(
  parameter int PRESCALE = 8,
  parameter int LO_W     = 16,
  parameter int HI_W     = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 restart_i,
  input  logic                 rd_req_i,
  output logic                 rd_valid_o,
  output logic [LO_W+HI_W-1:0] rd_data_o
);
  logic            tick_w;
  logic            rise_w;
  logic [LO_W-1:0] lo_w;
  logic [HI_W-1:0] hi_w;

  ctr_prescale #(.DIV(PRESCALE)) u_pre (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (restart_i),
    .tick_o    (tick_w)
  );

  ctr_low_stage #(.W(LO_W)) u_lo (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .restart_i    (restart_i),
    .tick_i       (tick_w),
    .cnt_o        (lo_w),
    .carry_rise_o (rise_w)
  );

  ctr_high_stage #(.W(HI_W)) u_hi (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (restart_i),
    .step_i    (rise_w),
    .cnt_o     (hi_w)
  );

  ctr_read_seq #(.LO_W(LO_W), .HI_W(HI_W)) u_rd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (restart_i),
    .req_i     (rd_req_i),
    .lo_i      (lo_w),
    .hi_i      (hi_w),
    .valid_o   (rd_valid_o),
    .data_o    (rd_data_o)
  );

  // R3
  hi_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(hi_w) && !$past(restart_i)) |-> (lo_w == '0 && hi_w == $past(hi_w) + 1'b1));

  // R8
  restart_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(restart_i) |-> (lo_w == '0 && hi_w == '0));
endmodule

// File: tb/sim_chain_ctr32.sv
module sim_chain_ctr32;
  localparam int PRE = 8;
  localparam int LW  = 6;
  localparam int HW  = 4;
  localparam int W   = LW + HW;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         restart = 1'b0;
  logic         req = 1'b0;
  logic         rd_valid;
  logic [W-1:0] rd_data;

  int total = 0;
  int bad   = 0;
  string cur_tag = "R1";

  always #5 clk = ~clk;

  chain_ctr32 #(.PRESCALE(PRE), .LO_W(LW), .HI_W(HW)) u0 (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .restart_i  (restart),
    .rd_req_i   (req),
    .rd_valid_o (rd_valid),
    .rd_data_o  (rd_data)
  );

  task automatic chk(input string tag, input bit ok, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: edge count since reset/restart, read phase
  int     k = 0;
  int     ph = 0;
  int     h1m = 0;
  int     ls = 0;
  bit     ev = 1'b0;
  longint ed = 0;
  int     retries = 0;
  int     pulses = 0;

  function automatic int true_cnt(input int kk);
    return (kk / PRE) % (1 << W);
  endfunction

  // upper half visible after kk edges: steps one edge after the lower wrap
  function automatic int hi_seen(input int kk);
    if (kk == 0) return 0;
    return (((kk - 1) / PRE) >> LW) % (1 << HW);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      k = 0; ph = 0; ev = 1'b0; ed = 0;
    end else begin
      ev = 1'b0;
      if (restart) begin
        ph = 0; k = 0;
      end else begin
        case (ph)
          0: if (req) begin h1m = hi_seen(k); ph = 1; end
          1: begin ls = k; ph = 2; end
          default: begin
            if (hi_seen(k) == h1m) begin
              ev = 1'b1; ed = longint'(true_cnt(ls)); ph = 0; pulses++;
            end else begin
              h1m = hi_seen(k); ph = 1; retries++;
            end
          end
        endcase
        k++;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      chk("R1", rd_valid == 1'b0, longint'(rd_valid), 0);
      chk("R1", rd_data == '0, longint'(rd_data), 0);
    end else begin
      chk(cur_tag, rd_valid == ev, longint'(rd_valid), longint'(ev));
      if (ev) chk("R4", longint'(rd_data) == ed, longint'(rd_data), ed);
    end
  end

  task automatic pulse_req();
    req = 1'b1; @(negedge clk); req = 1'b0;
  endtask

  task automatic do_restart();
    @(negedge clk); restart = 1'b1; @(negedge clk); restart = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R5: single read after reset
    cur_tag = "R5";
    pulse_req();
    repeat (6) @(negedge clk);

    // R2: reads at scattered spacing
    cur_tag = "R2";
    for (int i = 0; i < 80; i++) begin
      pulse_req();
      repeat ($urandom_range(3, 20)) @(negedge clk);
    end

    // R3: sweep request phase across the first lower wrap
    cur_tag = "R3";
    for (int n = 503; n <= 516; n++) begin
      do_restart();
      repeat (n) @(negedge clk);
      pulse_req();
      repeat (8) @(negedge clk);
    end
    chk("R6", retries > 0, longint'(retries), 1);

    // R7: request held high, in-flight requests ignored
    cur_tag = "R7";
    begin
      int p0;
      p0 = pulses;
      req = 1'b1;
      repeat (300) @(negedge clk);
      req = 1'b0;
      repeat (4) @(negedge clk);
      chk("R7", (pulses - p0) >= 95 && (pulses - p0) <= 100, longint'(pulses - p0), 100);
    end

    // R8: restart during a read, and restart with request at same edge
    cur_tag = "R8";
    pulse_req();
    restart = 1'b1; @(negedge clk); restart = 1'b0;
    repeat (5) @(negedge clk);
    req = 1'b1; restart = 1'b1; @(negedge clk); restart = 1'b0; req = 1'b0;
    repeat (5) @(negedge clk);
    pulse_req();
    repeat (5) @(negedge clk);

    // R9: continuous reads across the full combined wrap
    cur_tag = "R9";
    do_restart();
    repeat ((1 << W) * PRE - 40) @(negedge clk);
    req = 1'b1;
    repeat (80) @(negedge clk);
    req = 1'b0;
    repeat (6) @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(10 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule